// File: doc/BRIEF.md
# Tile-Matrix Object Renderer

This block draws the static game objects (gems, bombs and doors) that sit on a coarse grid over a 640x480 raster. A timing generator elsewhere supplies the pixel coordinate and the current level number each clock. The renderer works out which 32x32 cell the pixel falls in and finds the object that the level layout places there. It then reads that object's bitmap at the pixel's offset inside the cell. One clock later it presents an 8-bit colour and a flag that tells a downstream mixer whether this layer wants the pixel.

The layout of each level is computed from the level number and the cell position, so it needs no stored table. On top of that layout the block keeps one erase bit per cell. When the player touches an object, the game logic sends a one-cycle strobe that names the cell. From then on the object is treated as gone and is not drawn, until the level changes or the block is reset. Either of those brings back the level's full starting layout.

Top module: `obj_tile_renderer`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, draw_q is 0 and rgb_q is 0. Reset clears every erase bit, so each cell shows its layout object again.
- R2: The cell column is px_x[9:5] and the cell row is px_y[8:5]. The offset inside the bitmap is ox = px_x[4:0] and oy = px_y[4:0]. A column of 20 or more, or a row of 15 or more, counts as an empty cell.
- R3: The layout object code of a cell is computed as follows. Take v = (3*row + 5*col + 7*level) mod 8. The code is v when v < 4 and 0 otherwise. The codes are 0 empty, 1 gem, 2 bomb and 3 door.
- R4: Let dx = ox-16 and dy = oy-16. The bitmaps work like this:
  - A gem is 8'h1F where |dx|+|dy| <= 10.
  - A bomb is 8'hE0 where dx*dx+dy*dy <= 100.
  - A door is 8'h8C where 4 <= ox <= 27 and oy >= 2.
  - Every other pixel, and every pixel of an empty cell, holds the transparent key 8'hE3.
- R5: draw_q is 1 only when the bitmap value differs from the transparent key. rgb_q then carries the bitmap value. When draw_q is 0, rgb_q is 0.
- R6: The result for the inputs presented in one cycle appears on draw_q and rgb_q after exactly one rising clock edge.
- R7: A collision strobe (coll_stb=1 for one cycle, with coll_row and coll_col) erases that cell at the next rising edge. A pixel in that cell that is presented in the same cycle as the strobe is still drawn. The same pixel presented in any later cycle is not drawn.
- R8: A collision strobe that names a row of 15 or more, or a column of 20 or more, changes no cell.
- R9: When the level input differs from its value in the previous cycle, all erase bits are cleared at that edge. A collision strobe in that same cycle is dropped. The new level's layout is drawn in full from that cycle onward.
- R10: An erased cell stays erased while the level is unchanged. A strobe affects only the cell it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| level | input | 2 | Current level number |
| px_x | input | 10 | Pixel column from the timing generator |
| px_y | input | 9 | Pixel row from the timing generator |
| coll_stb | input | 1 | One-cycle collision strobe |
| coll_row | input | 4 | Cell row of the collided object |
| coll_col | input | 5 | Cell column of the collided object |
| draw_q | output | 1 | Drawing request for this layer |
| rgb_q | output | 8 | Pixel colour, valid with draw_q |

## Verification
The bench aims at the exact edges of each bitmap, one pixel inside and one pixel outside. A wrong comparison or a wrong centre would move a shape by one pixel and flip a request. It probes cells past column 19 and row 14 whose layout formula would give an object, so a design that does not range-check would draw there. It also sends an out-of-range strobe at column 23 of row 0. A design that computes the row-major index without a range check would wrongly erase the bomb at row 1, column 3. Finally, it checks the erase timing around the strobe cycle, a strobe that coincides with a level change, and recovery after reset. A design with an extra register stage, or one that lets a stale erase survive a level change, would fail these checks.

// File: rtl/otr_pkg.sv
package otr_pkg;

    typedef enum logic [1:0] {
        OBJ_EMPTY = 2'd0,
        OBJ_GEM   = 2'd1,
        OBJ_BOMB  = 2'd2,
        OBJ_DOOR  = 2'd3
    } obj_code_e;

    localparam logic [7:0] GEM_RGB  = 8'h1F;
    localparam logic [7:0] BOMB_RGB = 8'hE0;
    localparam logic [7:0] DOOR_RGB = 8'h8C;

    typedef struct packed {
        logic       draw;
        logic [7:0] rgb;
    } pix_out_t;

endpackage

// File: rtl/otr_cell_decode.sv
module otr_cell_decode #(
    parameter int X_W        = 10,
    parameter int Y_W        = 9,
    parameter int CELL_SHIFT = 5,
    parameter int COLS       = 20,
    parameter int ROWS       = 15,
    localparam int COL_W     = X_W - CELL_SHIFT,
    localparam int ROW_W     = Y_W - CELL_SHIFT
) (
    input  logic [X_W-1:0]        px_x,
    input  logic [Y_W-1:0]        px_y,
    output logic [COL_W-1:0]      col,
    output logic [ROW_W-1:0]      row,
    output logic [CELL_SHIFT-1:0] ox,
    output logic [CELL_SHIFT-1:0] oy,
    output logic                  in_grid
);

    always_comb begin
        col     = px_x[X_W-1:CELL_SHIFT];
        row     = px_y[Y_W-1:CELL_SHIFT];
        ox      = px_x[CELL_SHIFT-1:0];
        oy      = px_y[CELL_SHIFT-1:0];
        in_grid = (int'(col) < COLS) && (int'(row) < ROWS);
    end

endmodule

// File: rtl/otr_layout.sv
module otr_layout
    import otr_pkg::*;
#(
    parameter int COL_W = 5,
    parameter int ROW_W = 4,
    parameter int LVL_W = 2
) (
    input  logic [LVL_W-1:0] level,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output obj_code_e        code
);

    logic [7:0] mix;

    always_comb begin
        mix  = 8'(row) * 8'd3 + 8'(col) * 8'd5 + 8'(level) * 8'd7;
        code = mix[2] ? OBJ_EMPTY : obj_code_e'(mix[1:0]);
    end

endmodule

// File: rtl/otr_bitmap.sv
module otr_bitmap
    import otr_pkg::*;
#(
    parameter int         CELL_SHIFT = 5,
    parameter logic [7:0] TRANSP_KEY = 8'hE3
) (
    input  obj_code_e             code,
    input  logic [CELL_SHIFT-1:0] ox,
    input  logic [CELL_SHIFT-1:0] oy,
    output logic [7:0]            colour
);

    localparam int CELL     = 1 << CELL_SHIFT;
    localparam int HALF     = CELL / 2;
    localparam int GEM_R    = (HALF * 5) / 8;
    localparam int BOMB_R2  = GEM_R * GEM_R;
    localparam int DOOR_LO  = HALF / 4;
    localparam int DOOR_HI  = CELL - 1 - DOOR_LO;
    localparam int DOOR_TOP = HALF / 8;

    int dx;
    int dy;
    int adx;
    int ady;
    logic in_gem;
    logic in_bomb;
    logic in_door;

    always_comb begin
        dx      = int'(ox) - HALF;
        dy      = int'(oy) - HALF;
        adx     = (dx < 0) ? -dx : dx;
        ady     = (dy < 0) ? -dy : dy;
        in_gem  = (adx + ady) <= GEM_R;
        in_bomb = (dx * dx + dy * dy) <= BOMB_R2;
        in_door = (int'(ox) >= DOOR_LO) && (int'(ox) <= DOOR_HI) && (int'(oy) >= DOOR_TOP);
        unique case (code)
            OBJ_GEM:  colour = in_gem  ? GEM_RGB  : TRANSP_KEY;
            OBJ_BOMB: colour = in_bomb ? BOMB_RGB : TRANSP_KEY;
            OBJ_DOOR: colour = in_door ? DOOR_RGB : TRANSP_KEY;
            default:  colour = TRANSP_KEY;
        endcase
    end

endmodule

// File: rtl/otr_erase_grid.sv
module otr_erase_grid #(
    parameter int COLS  = 20,
    parameter int ROWS  = 15,
    parameter int COL_W = 5,
    parameter int ROW_W = 4,
    parameter int LVL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [ROW_W-1:0] rd_row,
    input  logic [COL_W-1:0] rd_col,
    input  logic             rd_valid,
    input  logic             coll_stb,
    input  logic [ROW_W-1:0] coll_row,
    input  logic [COL_W-1:0] coll_col,
    output logic             rd_erased
);

    localparam int CELLS = COLS * ROWS;
    localparam int IDX_W = $clog2(CELLS);

    typedef struct packed {
        logic [CELLS-1:0] mask;
        logic [LVL_W-1:0] lvl;
    } grid_t;

    grid_t            grid_d;
    grid_t            grid_q;
    logic             lvl_same;
    logic             coll_valid;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;

    always_comb begin
        lvl_same   = (level == grid_q.lvl);
        coll_valid = coll_stb && (int'(coll_row) < ROWS) && (int'(coll_col) < COLS);
        rd_idx     = rd_valid ? IDX_W'(rd_row) * IDX_W'(COLS) + IDX_W'(rd_col) : '0;
        wr_idx     = coll_valid ? IDX_W'(coll_row) * IDX_W'(COLS) + IDX_W'(coll_col) : '0;
        rd_erased  = rd_valid && lvl_same && grid_q.mask[rd_idx];

        grid_d     = grid_q;
        grid_d.lvl = level;
        if (!lvl_same) begin
            grid_d.mask = '0;
        end else if (coll_valid) begin
            grid_d.mask[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grid_q <= '0;
        end else begin
            grid_q <= grid_d;
        end
    end

    AST_ERASE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_valid && lvl_same) |=> grid_q.mask[$past(wr_idx)]); // R7

    AST_RANGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_stb && !coll_valid && lvl_same) |=> (grid_q.mask == $past(grid_q.mask))); // R8

    AST_LEVEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_same) |=> (grid_q.mask == '0)); // R9

    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_same |=> ((grid_q.mask & $past(grid_q.mask)) == $past(grid_q.mask))); // R10

    AST_SINGLE_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(grid_q.mask & ~$past(grid_q.mask)) <= 1)); // R10

endmodule

// File: rtl/obj_tile_renderer.sv
module obj_tile_renderer
    import otr_pkg::*;
#(
    parameter int         X_W        = 10,
    parameter int         Y_W        = 9,
    parameter int         CELL_SHIFT = 5,
    parameter int         COLS       = 20,
    parameter int         ROWS       = 15,
    parameter int         LVL_W      = 2,
    parameter logic [7:0] TRANSP_KEY = 8'hE3,
    localparam int        COL_W      = X_W - CELL_SHIFT,
    localparam int        ROW_W      = Y_W - CELL_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [X_W-1:0]   px_x,
    input  logic [Y_W-1:0]   px_y,
    input  logic             coll_stb,
    input  logic [ROW_W-1:0] coll_row,
    input  logic [COL_W-1:0] coll_col,
    output logic             draw_q,
    output logic [7:0]       rgb_q
);

    logic [COL_W-1:0]      cell_col;
    logic [ROW_W-1:0]      cell_row;
    logic [CELL_SHIFT-1:0] off_x;
    logic [CELL_SHIFT-1:0] off_y;
    logic                  in_grid;
    logic                  erased;
    obj_code_e             layout_code;
    obj_code_e             live_code;
    logic [7:0]            bm_colour;
    pix_out_t              out_d;
    pix_out_t              out_q;

    otr_cell_decode #(
        .X_W(X_W), .Y_W(Y_W), .CELL_SHIFT(CELL_SHIFT), .COLS(COLS), .ROWS(ROWS)
    ) u_decode (
        .px_x(px_x), .px_y(px_y), .col(cell_col), .row(cell_row),
        .ox(off_x), .oy(off_y), .in_grid(in_grid)
    );

    otr_layout #(
        .COL_W(COL_W), .ROW_W(ROW_W), .LVL_W(LVL_W)
    ) u_layout (
        .level(level), .row(cell_row), .col(cell_col), .code(layout_code)
    );

    otr_erase_grid #(
        .COLS(COLS), .ROWS(ROWS), .COL_W(COL_W), .ROW_W(ROW_W), .LVL_W(LVL_W)
    ) u_grid (
        .clk(clk), .rst_n(rst_n), .level(level),
        .rd_row(cell_row), .rd_col(cell_col), .rd_valid(in_grid),
        .coll_stb(coll_stb), .coll_row(coll_row), .coll_col(coll_col),
        .rd_erased(erased)
    );

    always_comb begin
        live_code = (in_grid && !erased) ? layout_code : OBJ_EMPTY;
    end

    otr_bitmap #(
        .CELL_SHIFT(CELL_SHIFT), .TRANSP_KEY(TRANSP_KEY)
    ) u_bitmap (
        .code(live_code), .ox(off_x), .oy(off_y), .colour(bm_colour)
    );

    always_comb begin
        out_d.draw = (bm_colour != TRANSP_KEY);
        out_d.rgb  = out_d.draw ? bm_colour : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign draw_q = out_q.draw;
    assign rgb_q  = out_q.rgb;

    AST_KEY_NEVER_DRAWN: assert property (@(posedge clk) disable iff (!rst_n)
        draw_q |-> (rgb_q != TRANSP_KEY)); // R5

    AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (live_code == OBJ_EMPTY) |=> !draw_q); // R2

    AST_ERASED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        erased |=> !draw_q); // R7

endmodule

// File: tb/obj_tile_renderer_tb_top.sv
module obj_tile_renderer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] level = '0;
    logic [9:0] px_x = '0;
    logic [8:0] px_y = '0;
    logic       coll_stb = 1'b0;
    logic [3:0] coll_row = '0;
    logic [4:0] coll_col = '0;
    logic       draw_q;
    logic [7:0] rgb_q;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // model state
    bit         m_erased [15][20];
    logic [1:0] m_lvl = '0;

    always #10 clk = ~clk;

    obj_tile_renderer dut_i (
        .clk(clk), .rst_n(rst_n), .level(level), .px_x(px_x), .px_y(px_y),
        .coll_stb(coll_stb), .coll_row(coll_row), .coll_col(coll_col),
        .draw_q(draw_q), .rgb_q(rgb_q)
    );

    typedef struct packed {
        logic [9:0]  x;
        logic [8:0]  y;
        logic [1:0]  l;
        logic        d;
        logic [7:0]  c;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{10'd16,  9'd16,  2'd0, 1'b0, 8'h00, "R3 "},
        '{10'd80,  9'd16,  2'd0, 1'b1, 8'hE0, "R3 "},
        '{10'd176, 9'd16,  2'd0, 1'b1, 8'h1F, "R3 "},
        '{10'd240, 9'd16,  2'd0, 1'b1, 8'h8C, "R3 "},
        '{10'd64,  9'd0,   2'd0, 1'b0, 8'h00, "R5 "},
        '{10'd688, 9'd16,  2'd0, 1'b0, 8'h00, "R2 "},
        '{10'd48,  9'd496, 2'd0, 1'b0, 8'h00, "R2 "},
        '{10'd227, 9'd16,  2'd0, 1'b0, 8'h00, "R4 "},
        '{10'd228, 9'd16,  2'd0, 1'b1, 8'h8C, "R4 "},
        '{10'd186, 9'd16,  2'd0, 1'b1, 8'h1F, "R4 "},
        '{10'd187, 9'd16,  2'd0, 1'b0, 8'h00, "R4 "},
        '{10'd90,  9'd16,  2'd0, 1'b1, 8'hE0, "R4 "},
        '{10'd91,  9'd16,  2'd0, 1'b0, 8'h00, "R4 "},
        '{10'd240, 9'd1,   2'd0, 1'b0, 8'h00, "R4 "},
        '{10'd240, 9'd2,   2'd0, 1'b1, 8'h8C, "R4 "},
        '{10'd80,  9'd16,  2'd1, 1'b1, 8'h1F, "R9 "},
        '{10'd16,  9'd16,  2'd1, 1'b0, 8'h00, "R3 "},
        '{10'd80,  9'd16,  2'd0, 1'b1, 8'hE0, "R9 "}
    };

    function automatic logic [8:0] model_pix(input logic [9:0] x, input logic [8:0] y,
                                             input logic [1:0] l, input bit gone);
        int c, r, ox, oy, dx, dy, v, code;
        logic [7:0] px;
        c  = int'(x) / 32;
        r  = int'(y) / 32;
        ox = int'(x) % 32;
        oy = int'(y) % 32;
        dx = ox - 16;
        dy = oy - 16;
        v  = (3 * r + 5 * c + 7 * int'(l)) % 8;
        code = (v < 4) ? v : 0;
        if (c >= 20 || r >= 15 || gone) code = 0;
        px = 8'hE3;
        if (code == 1 && ((dx < 0 ? -dx : dx) + (dy < 0 ? -dy : dy)) <= 10) px = 8'h1F;
        if (code == 2 && (dx * dx + dy * dy) <= 100) px = 8'hE0;
        if (code == 3 && ox >= 4 && ox <= 27 && oy >= 2) px = 8'h8C;
        return (px == 8'hE3) ? 9'h000 : {1'b1, px};
    endfunction

    task automatic check(input string req, input logic [8:0] exp);
        n_checks++;
        if ({draw_q, rgb_q} !== exp) begin
            n_fail++;
            $display("FAIL %s: draw/rgb = %0b/%02h, expected %0b/%02h",
                     req, draw_q, rgb_q, exp[8], exp[7:0]);
        end
    endtask

    function automatic void model_clear();
        for (int r = 0; r < 15; r++)
            for (int c = 0; c < 20; c++)
                m_erased[r][c] = 1'b0;
    endfunction

    // Drive at a falling edge, pass one rising edge, return at the next falling edge.
    task automatic step(input logic [9:0] x, input logic [8:0] y, input logic [1:0] l,
                        input bit stb, input int cr, input int cc, output logic [8:0] exp);
        int r, c;
        bit gone;
        px_x = x; px_y = y; level = l;
        coll_stb = stb; coll_row = 4'(cr); coll_col = 5'(cc);
        r = int'(y) / 32;
        c = int'(x) / 32;
        gone = (l == m_lvl) && r < 15 && c < 20 && m_erased[r][c];
        exp = model_pix(x, y, l, gone);
        @(posedge clk);
        if (l != m_lvl) model_clear();
        else if (stb && cr < 15 && cc < 20) m_erased[cr][cc] = 1'b1;
        m_lvl = l;
        @(negedge clk);
        coll_stb = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 (in reset)", 9'h000);
        model_clear();
        m_lvl = '0;
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung, expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [8:0] e;
        px_x = 10'd80; px_y = 9'd16;
        do_reset();
        #1 check("R1 (after release, before edge)", 9'h000);
        @(negedge clk);
        check("R6 first registered result", 9'h1E0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].x, VECS[i].y, VECS[i].l, 1'b0, 0, 0, e);
            check(string'(VECS[i].tag), {VECS[i].d, VECS[i].c});
            check("R4 model agreement", e);
        end

        // R6: output holds the previous result until the edge
        step(10'd16, 9'd16, 2'd0, 1'b0, 0, 0, e);
        px_x = 10'd176; px_y = 9'd16;
        #1 check("R6 before edge", 9'h000);
        @(negedge clk);
        check("R6 one edge later", 9'h11F);

        // R7: strobe on row0 col2 bomb, same-cycle pixel still drawn
        step(10'd80, 9'd16, 2'd0, 1'b1, 0, 2, e);
        check("R7 same cycle", 9'h1E0);
        step(10'd80, 9'd16, 2'd0, 1'b0, 0, 0, e);
        check("R7 erased next cycle", 9'h000);
        step(10'd176, 9'd16, 2'd0, 1'b0, 0, 0, e);
        check("R10 neighbour gem intact", 9'h11F);
        repeat (5) step(10'd90, 9'd16, 2'd0, 1'b0, 0, 0, e);
        check("R10 erase persists", 9'h000);

        // R8: out-of-range strobe at row0 col23 must not hit row1 col3 bomb
        step(10'd112, 9'd48, 2'd0, 1'b1, 0, 23, e);
        step(10'd112, 9'd48, 2'd0, 1'b0, 0, 0, e);
        check("R8 row1 col3 bomb intact", 9'h1E0);
        step(10'd112, 9'd48, 2'd0, 1'b1, 15, 1, e);
        step(10'd112, 9'd48, 2'd0, 1'b0, 0, 0, e);
        check("R8 row15 strobe ignored", 9'h1E0);

        // R9: level change restores, strobe in change cycle dropped
        step(10'd80, 9'd16, 2'd1, 1'b1, 0, 2, e);
        check("R9 change cycle", 9'h11F);
        step(10'd80, 9'd16, 2'd1, 1'b0, 0, 0, e);
        check("R9 strobe during change dropped", 9'h11F);
        step(10'd80, 9'd16, 2'd0, 1'b0, 0, 0, e);
        check("R9 bomb restored on return", 9'h1E0);

        // R1: reset restores an erased cell
        step(10'd176, 9'd16, 2'd0, 1'b1, 0, 5, e);
        step(10'd176, 9'd16, 2'd0, 1'b0, 0, 0, e);
        check("R7 gem erased", 9'h000);
        do_reset();
        @(negedge clk);
        check("R1 gem back after reset", 9'h11F);

        // sweep on level 2 against the model, with some erasures
        step(10'd0, 9'd0, 2'd2, 1'b0, 0, 0, e);
        step(10'd0, 9'd0, 2'd2, 1'b1, 3, 4, e);
        step(10'd0, 9'd0, 2'd2, 1'b1, 7, 11, e);
        for (int r = 0; r < 16; r++) begin
            for (int c = 0; c < 32; c++) begin
                for (int k = 0; k < 3; k++) begin
                    step(10'(c * 32 + 16 - 6 * k), 9'(r * 32 + 16 + 5 * k), 2'd2, 1'b0, 0, 0, e);
                    check("R3 R4 R5 sweep", e);
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule